// File: doc/BRIEF.md
# I2C Target with Polled Message Stream

This block is an I2C target that lets a bus host drain a byte stream of messages produced inside the chip. Local logic pushes message bytes into an internal FIFO through a valid/ready handshake. The host polls a two-byte pending-count register pair, then reads a stream register. Each read of the stream register removes one byte from the FIFO. When the FIFO is empty, the stream register returns the fill value 0xFF.

The host selects a register by writing its address after the write address byte. It then reads, either after a repeated START (a random read) or in a later transaction. The register pointer steps forward after each byte read and stops at the stream register, so a long burst keeps draining the stream. The stream channel is closed after reset and closes again when the host has not read the stream register for a programmable number of clock cycles. While the channel is closed, no new bytes are accepted. A read of the stream register opens it.

SCL and SDA are sampled on the system clock. The target drives both lines only by pulling them low. It holds SCL low for one cycle while it loads each byte to be read.

Top module: `i2c_msg_target`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x42, which gives a write address byte of 0x84 and a read address byte of 0x85. Any other address is not acknowledged, and the target leaves SDA released until the next START.
- R2: Register 0xFD returns bits 15:8 and register 0xFE returns bits 7:0 of the number of bytes waiting in the FIFO. Both read 0x00 when the FIFO is empty.
- R3: Each read of register 0xFF returns the oldest FIFO byte and removes it. If the FIFO is empty, the read returns 0xFF and removes nothing.
- R4: The register pointer advances by one after each byte read, and it stays at 0xFF once it has reached 0xFF.
- R5: Registers 0x00 through 0xFC read as 0x00.
- R6: The first data byte of a write sets the register pointer. The pointer keeps its value across a repeated START and across a STOP. Later bytes in the same write are acknowledged and have no effect.
- R7: The stream channel is closed after reset. It also closes when TIMEOUT_CYCLES clock cycles pass without a read of register 0xFF. While the channel is closed, push_ready is low and no byte is stored. A read of register 0xFF opens the channel.
- R8: A NACK from the host after a read byte ends the burst, and no further FIFO byte is removed.
- R9: A byte is stored when push_valid and push_ready are both high at a clock edge. push_ready is low while the FIFO holds FIFO_DEPTH bytes.
- R10: The target pulls SCL low while it loads each byte to be read. It does this only after SCL has gone low.
- R11: When register 0xFE is read in the same burst directly after register 0xFD, it returns the low byte of the count captured at the 0xFD read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| push_valid | input | 1 | Local message byte is offered |
| push_data | input | 8 | Local message byte |
| push_ready | output | 1 | Channel open and FIFO not full |

## Verification
The bench goes after three points where the pointer, the stream and the channel interact.

The first is a burst that starts below 0xFD and runs past 0xFF. A pointer that wraps to 0x00 instead of stopping would return zeros in place of stream bytes.

The second is a read of the empty stream. A design that pops anyway would lose the next byte pushed. A design that returns zero would make an empty stream look like data.

The third is a NACK on a single stream read, followed by a second read. A design that prefetches the next byte would skip a byte.

The bench also waits out the inactivity window. It then offers bytes and reads the count to prove that nothing was stored while the channel was closed. A write-only pointer set followed by a later current-address read shows whether the pointer survives a STOP, and whether extra write bytes leak into it.

// File: rtl/i2c_msg_target_pkg.sv
package i2c_msg_target_pkg;

    localparam logic [6:0] DEV_ADDR     = 7'h42;
    localparam logic [7:0] REG_COUNT_HI = 8'hFD;
    localparam logic [7:0] REG_COUNT_LO = 8'hFE;
    localparam logic [7:0] REG_STREAM   = 8'hFF;
    localparam logic [7:0] EMPTY_FILL   = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WREG,
        ST_WACK,
        ST_WDATA,
        ST_RD_LOAD,
        ST_RD_BYTE,
        ST_RD_ACK
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e  state;
        logic [7:0]  shift;
        logic [3:0]  bitcnt;
        logic [7:0]  ptr;
        logic        rnw;
        logic        host_ack;
        logic [15:0] cnt_lat;
        logic        prev_hi;
        logic        chan_open;
        logic        sda_oe;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [1:0] scl_sync;
        logic [1:0] sda_sync;
        logic       scl_prev;
        logic       sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_sync = {s_q.scl_sync[0], scl_i};
        s_d.sda_sync = {s_q.sda_sync[0], sda_i};
        s_d.scl_prev = s_q.scl_sync[1];
        s_d.sda_prev = s_q.sda_sync[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s    = s_q.scl_sync[1];
    assign sda_s    = s_q.sda_sync[1];
    assign scl_rise = scl_s & ~s_q.scl_prev;
    assign scl_fall = ~scl_s & s_q.scl_prev;
    assign start_ev = scl_s & s_q.scl_prev & s_q.sda_prev & ~sda_s;
    assign stop_ev  = scl_s & s_q.scl_prev & ~s_q.sda_prev & sda_s;

endmodule

// File: rtl/msg_byte_fifo.sv
module msg_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    count,
    output logic             full
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wp_d, wp_q, rp_d, rp_q;
    logic [CW-1:0]    cnt_d, cnt_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        wp_d  = wr_en ? step(wp_q) : wp_q;
        rp_d  = rd_en ? step(rp_q) : rp_q;
        cnt_d = cnt_q + CW'(wr_en) - CW'(rd_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wp_q] <= wr_data;
    end

    assign rd_data = mem_q[rp_q];
    assign count   = cnt_q;
    assign full    = (cnt_q == CW'(DEPTH));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (cnt_q < CW'(DEPTH)));
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (cnt_q != '0));

endmodule

// File: rtl/i2c_msg_target.sv
module i2c_msg_target
    import i2c_msg_target_pkg::*;
#(
    parameter int FIFO_DEPTH     = 64,
    parameter int TIMEOUT_CYCLES = 100_000_000,
    localparam int CW = $clog2(FIFO_DEPTH + 1),
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       push_valid,
    input  logic [7:0] push_data,
    output logic       push_ready
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic          fifo_wr, fifo_rd, fifo_full;
    logic [7:0]    fifo_head;
    logic [CW-1:0] fifo_cnt;
    logic [15:0]   pending;

    tgt_regs_t     r_d, r_q;
    logic [TW-1:0] timer_d, timer_q;
    logic [7:0]    load_byte;

    i2c_line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    msg_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fifo_wr),
        .wr_data (push_data),
        .rd_en   (fifo_rd),
        .rd_data (fifo_head),
        .count   (fifo_cnt),
        .full    (fifo_full)
    );

    assign pending    = 16'(fifo_cnt);
    assign push_ready = r_q.chan_open & ~fifo_full;
    assign fifo_wr    = push_valid & push_ready;

    always_comb begin
        r_d       = r_q;
        timer_d   = timer_q;
        fifo_rd   = 1'b0;
        load_byte = 8'h00;

        // inactivity window on the stream register
        if (r_q.chan_open) begin
            if (timer_q == TW'(TIMEOUT_CYCLES - 1)) begin
                r_d.chan_open = 1'b0;
                timer_d       = '0;
            end else begin
                timer_d = timer_q + TW'(1);
            end
        end

        if (stop_ev) begin
            r_d.state  = ST_IDLE;
            r_d.sda_oe = 1'b0;
        end else if (start_ev) begin
            r_d.state   = ST_ADDR;
            r_d.bitcnt  = '0;
            r_d.sda_oe  = 1'b0;
            r_d.prev_hi = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_ADDR, ST_WREG, ST_WDATA: begin
                    if (scl_rise) begin
                        r_d.shift  = {r_q.shift[6:0], sda_s};
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end
                    if (scl_fall && r_q.bitcnt == 4'd8) begin
                        r_d.bitcnt = '0;
                        r_d.sda_oe = 1'b1;
                        if (r_q.state == ST_ADDR) begin
                            if (r_q.shift[7:1] == DEV_ADDR) begin
                                r_d.state = ST_ADDR_ACK;
                                r_d.rnw   = r_q.shift[0];
                            end else begin
                                r_d.state  = ST_IDLE;
                                r_d.sda_oe = 1'b0;
                            end
                        end else begin
                            if (r_q.state == ST_WREG) r_d.ptr = r_q.shift;
                            r_d.state = ST_WACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        r_d.sda_oe = 1'b0;
                        r_d.state  = r_q.rnw ? ST_RD_LOAD : ST_WREG;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        r_d.sda_oe = 1'b0;
                        r_d.state  = ST_WDATA;
                    end
                end
                ST_RD_LOAD: begin
                    unique case (r_q.ptr)
                        REG_COUNT_HI: begin
                            load_byte   = pending[15:8];
                            r_d.cnt_lat = pending;
                        end
                        REG_COUNT_LO: begin
                            load_byte = r_q.prev_hi ? r_q.cnt_lat[7:0] : pending[7:0];
                        end
                        REG_STREAM: begin
                            load_byte     = (fifo_cnt == '0) ? EMPTY_FILL : fifo_head;
                            fifo_rd       = (fifo_cnt != '0);
                            r_d.chan_open = 1'b1;
                            timer_d       = '0;
                        end
                        default: load_byte = 8'h00;
                    endcase
                    r_d.prev_hi = (r_q.ptr == REG_COUNT_HI);
                    r_d.ptr     = (r_q.ptr == REG_STREAM) ? REG_STREAM : r_q.ptr + 8'd1;
                    r_d.shift   = load_byte;
                    r_d.bitcnt  = '0;
                    r_d.sda_oe  = ~load_byte[7];
                    r_d.state   = ST_RD_BYTE;
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (r_q.bitcnt == 4'd7) begin
                            r_d.sda_oe = 1'b0;
                            r_d.state  = ST_RD_ACK;
                        end else begin
                            r_d.shift  = {r_q.shift[6:0], 1'b0};
                            r_d.bitcnt = r_q.bitcnt + 4'd1;
                            r_d.sda_oe = ~r_q.shift[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) r_d.host_ack = ~sda_s;
                    if (scl_fall) r_d.state = r_q.host_ack ? ST_RD_LOAD : ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            timer_q <= '0;
        end else begin
            r_q     <= r_d;
            timer_q <= timer_d;
        end
    end

    assign sda_oe = r_q.sda_oe;
    assign scl_oe = (r_q.state == ST_RD_LOAD);

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> !sda_oe);
    assert_ptr_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RD_LOAD && r_q.ptr == REG_STREAM) |=> (r_q.ptr == REG_STREAM));
    assert_timeout_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.chan_open) |-> ($past(timer_q) == TW'(TIMEOUT_CYCLES - 1)));
    assert_stretch_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !scl_s);

endmodule

// File: tb/i2c_msg_target_tb.sv
module i2c_msg_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int DEPTH      = 8;
    localparam int TMO        = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1, sda_h = 1'b1;
    logic scl_oe, sda_oe, push_valid, push_ready;
    logic [7:0] push_data;
    wire  scl = scl_h & ~scl_oe;
    wire  sda = sda_h & ~sda_oe;

    int n_tests = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_byte;
    event       obs_ev;
    bit         saw_stretch = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_msg_target #(.FIFO_DEPTH(DEPTH), .TIMEOUT_CYCLES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial forever begin
        @(obs_ev);
        if (exp_q.size() == 0) check(1'b0, "unexpected byte", obs_byte, 0);
        else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(obs_byte == e, t, obs_byte, e);
        end
    end

    always @(negedge clk) if (scl_oe) saw_stretch = 1'b1;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wait_high();
        cyc(1);
        while (!scl) cyc(1);
    endtask
    task automatic h_start();
        sda_h = 1; cyc(HALF); scl_h = 1; wait_high(); cyc(HALF);
        sda_h = 0; cyc(HALF); scl_h = 0; cyc(HALF);
    endtask
    task automatic h_stop();
        sda_h = 0; cyc(HALF); scl_h = 1; wait_high(); cyc(HALF);
        sda_h = 1; cyc(HALF);
    endtask
    task automatic bit_out(input logic b);
        sda_h = b; cyc(HALF); scl_h = 1; wait_high(); cyc(HALF); scl_h = 0; cyc(4);
    endtask
    task automatic bit_in(output logic b);
        sda_h = 1; cyc(HALF); scl_h = 1; wait_high(); cyc(HALF/2);
        b = sda; cyc(HALF/2); scl_h = 0; cyc(4);
    endtask
    task automatic byte_out(input logic [7:0] v, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        ack = !a;
    endtask
    task automatic byte_in(output logic [7:0] v, input bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin bit_in(b); v[i] = b; end
        bit_out(!ack);
    endtask

    task automatic expect_bytes(input logic [7:0] v[], input string tag);
        foreach (v[i]) begin exp_q.push_back(v[i]); tag_q.push_back(tag); end
    endtask

    task automatic read_bytes(input int n);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            byte_in(b, i < n - 1);
            obs_byte = b;
            -> obs_ev;
            cyc(2);
        end
    endtask

    // random read: register write, repeated START, read burst
    task automatic rd_reg(input logic [7:0] reg_a, input int n, input string tag);
        bit ack;
        h_start();
        byte_out(8'h84, ack); check(ack, {tag, " addr ack"}, ack, 1);
        byte_out(reg_a, ack);
        h_start();
        byte_out(8'h85, ack); check(ack, {tag, " raddr ack"}, ack, 1);
        read_bytes(n);
        h_stop();
    endtask

    task automatic push(input logic [7:0] v);
        @(negedge clk);
        while (!push_ready) @(negedge clk);
        push_valid = 1; push_data = v;
        @(negedge clk);
        push_valid = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit ack;
        push_valid = 0; push_data = 0;
        cyc(5); rst_n = 1; cyc(5);

        check(!sda_oe && !scl_oe, "reset lines released R1", {scl_oe, sda_oe}, 0);
        check(!push_ready, "R7 closed after reset", push_ready, 0);

        expect_bytes('{8'h00, 8'h00}, "R2 empty count");
        rd_reg(8'hFD, 2, "R2");

        push_valid = 1; push_data = 8'hEE; cyc(6); push_valid = 0;
        check(!push_ready, "R7 no push while closed", push_ready, 0);

        expect_bytes('{8'hFF}, "R3 empty fill");
        rd_reg(8'hFF, 1, "R3");
        check(push_ready, "R7 opened by stream read", push_ready, 1);

        push(8'hA1); push(8'hB2); push(8'hC3);
        expect_bytes('{8'h00, 8'h03}, "R2 R11 count pair");
        rd_reg(8'hFD, 2, "R2");
        expect_bytes('{8'hA1, 8'hB2, 8'hC3, 8'hFF}, "R3 R4 stream drain");
        rd_reg(8'hFF, 4, "R3");

        push(8'h55); push(8'h66);
        expect_bytes('{8'h00, 8'h00, 8'h02, 8'h55, 8'h66}, "R4 R5 burst from FC");
        rd_reg(8'hFC, 5, "R4");
        expect_bytes('{8'h00, 8'h00}, "R5 undefined reads zero");
        rd_reg(8'h10, 2, "R5");

        // R1: foreign address not acknowledged
        h_start();
        byte_out(8'hA0, ack);
        check(!ack, "R1 foreign address nack", ack, 0);
        h_stop();

        // R6: pointer set by write-only transaction, extra bytes ignored
        h_start();
        byte_out(8'h84, ack); check(ack, "R1 write address ack", ack, 1);
        byte_out(8'hFE, ack);
        byte_out(8'h77, ack); check(ack, "R6 extra byte acked", ack, 1);
        h_stop();
        push(8'h99);
        expect_bytes('{8'h01}, "R6 pointer kept across STOP");
        h_start();
        byte_out(8'h85, ack);
        read_bytes(1);
        h_stop();
        expect_bytes('{8'h99}, "R3 stream after pointer test");
        rd_reg(8'hFF, 1, "R3");

        // R8: NACK ends burst without a further pop
        push(8'h11); push(8'h22);
        expect_bytes('{8'h11}, "R8 first single read");
        rd_reg(8'hFF, 1, "R8");
        expect_bytes('{8'h22}, "R8 no byte lost");
        rd_reg(8'hFF, 1, "R8");
        expect_bytes('{8'hFF}, "R8 empty after");
        rd_reg(8'hFF, 1, "R8");

        // R9: FIFO full
        for (int i = 0; i < DEPTH; i++) push(8'h30 + 8'(i));
        cyc(2);
        check(!push_ready, "R9 ready low when full", push_ready, 0);
        push_valid = 1; push_data = 8'hEE; cyc(4); push_valid = 0;
        expect_bytes('{8'h00, 8'(DEPTH)}, "R9 R11 full count");
        rd_reg(8'hFD, 2, "R9");
        expect_bytes('{8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'hFF},
                     "R9 full drain");
        rd_reg(8'hFF, 9, "R9");

        check(saw_stretch, "R10 SCL stretched on read load", saw_stretch, 1);

        // R7: inactivity shutdown
        check(push_ready, "R7 open before idle", push_ready, 1);
        cyc(TMO + 500);
        check(!push_ready, "R7 closed after idle window", push_ready, 0);
        push_valid = 1; push_data = 8'hEE; cyc(10); push_valid = 0;
        expect_bytes('{8'h00, 8'h00}, "R7 nothing stored while closed");
        rd_reg(8'hFD, 2, "R7");
        expect_bytes('{8'hFF}, "R7 reopen read");
        rd_reg(8'hFF, 1, "R7");
        check(push_ready, "R7 reopened", push_ready, 1);

        cyc(20);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule